// File: doc/BRIEF.md
# Stack Push-All / Pop-All Sequencer

This block runs stack transfers for a 16-bit processor core. It handles four operations: a single-word push, a single-word pop, a push of every general register, and a pop of every general register. The block owns the stack pointer. It issues one word access per clock to a word-addressed stack memory. When the operation ends it raises a one-cycle completion strobe. Popped words go back to the register file, or to a segment register, through a writeback strobe.

The core starts an operation with a one-cycle `start`. With it the core gives:

- the operation code;
- a byte-size flag;
- the word to push, or the destination code for a pop.

The general register file is presented to the block as one flat vector. For a push-all, the block reads register `k` from that vector in the cycle in which it writes that register's slot. The block's own stack-pointer copy takes the place of the register file's stack-pointer slot. A request that the stack cannot accept is answered with completion plus an error flag. Such a request makes no memory access and leaves the pointer unchanged.

Top module: `stk_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `err`, `mem_we`, `mem_re` and `wb_en` are low, and `sp_out` equals the `SP_RESET` parameter (default 0x0180).
- R2: A push (`op`=0) makes one write in the cycle after `start`.
  - The write goes to word address (SP-2)/2 and carries `src_word`.
  - `done` follows in the next cycle, and SP has become SP-2.
- R3: A pop (`op`=1) makes one read at word address SP/2 in the cycle after `start`.
  - In the next cycle `done` is high, SP has become SP+2, and `wb_en` presents the memory's read data with `wb_dst` equal to the requested destination.
  - Memory read data arrives one cycle after the read request.
- R4: A push-all (`op`=2) makes eight writes in consecutive cycles, starting the cycle after `start`.
  - Write `k` (k=0..7) goes to word address (SP0-2(k+1))/2, where SP0 is the pointer before the operation.
  - Write `k` carries register index `k`. Index 4 is the stack-pointer slot, and it carries SP0 rather than the register file's value.
- R5: `done` of a push-all comes in the cycle after the eighth write, and SP is then SP0-16.
- R6: A pop-all (`op`=3) makes eight reads in consecutive cycles, at word addresses (SP0+2k)/2.
  - Read `k` is written back, one cycle later, to register index 7-k.
  - The word read for index 4 is dropped and gives no writeback.
  - SP ends at SP0+16, and `done` coincides with the last writeback.
- R7: Any request with `byte_op`=1 is rejected. `done` and `err` rise together in the cycle after `start`, no memory access is made, and SP is unchanged.
- R8: A pop whose destination is the code segment (code 9) is rejected in the same way as R7. The destination is never written.
- R9: A pop with destination 4 (the stack pointer) raises no `wb_en`. Instead SP takes the popped word in the cycle after `done`.
- R10: `start` while `busy` is high is ignored. The running operation finishes unchanged, and the block is idle in the cycle after `done`.
- R11: `mem_we` and `mem_re` are never high together, and `done` lasts exactly one cycle.
- R12: Pop destination codes 0-7 select general registers and 8-11 select segment registers. A legal segment destination (8, 10 or 11) is written back with its code unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| op | input | 2 | 0 push, 1 pop, 2 push-all, 3 pop-all |
| byte_op | input | 1 | Byte-size request flag (always rejected) |
| src_word | input | 16 | Word for a single push |
| dst | input | 4 | Pop destination code |
| rf_flat | input | 128 | General registers, index k at bits [16k+15:16k] |
| mem_addr | output | 15 | Stack memory word address |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_re` |
| wb_en | output | 1 | Writeback strobe |
| wb_dst | output | 4 | Writeback destination code |
| wb_data | output | 16 | Writeback word |
| sp_out | output | 16 | Current stack pointer |
| busy | output | 1 | Operation in progress, including its completion cycle |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Rejection flag, high with `done` |

## Verification
Two things can fall in the same cycle during a pop-all. In the completion cycle, the writeback of the last word read lands together with `done`. In every earlier cycle, the writeback of one word coincides with the read of the next word. The bench provokes this with two push-all operations over two distinct register patterns, followed by two pop-alls. At each cycle it checks both the current read address and the writeback index and data, against a LIFO model worked out by hand.

A second overlap is a `start` pulse raised in the middle of a push-all. The bench judges it by the write addresses, the data and the final pointer, which must all stay as if no pulse had come.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [1:0] {
      OP_PUSH    = 2'd0,
      OP_POP     = 2'd1,
      OP_PUSHALL = 2'd2,
      OP_POPALL  = 2'd3
   } stk_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_FIN  = 2'd2
   } stk_st_e;

   // bit 0 of the code selects a read-type transfer
   function automatic logic op_is_read(stk_op_e o);
      return o[0];
   endfunction

   // bit 1 of the code selects the eight-word form
   function automatic logic op_is_multi(stk_op_e o);
      return o[1];
   endfunction

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
   import stk_pkg::*;
#(
   parameter int NREG = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      reject,
   input  stk_op_e                   op_in,
   output stk_st_e                   st,
   output logic [$clog2(NREG)-1:0]   cnt,
   output stk_op_e                   op_q,
   output logic                      err_q,
   output logic                      accept,
   output logic                      last
);

   localparam int CW = $clog2(NREG);
   localparam logic [CW-1:0] CNT_LAST = CW'(NREG - 1);

   assign accept = start && (st == ST_IDLE);
   assign last   = !op_is_multi(op_q) || (cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         op_q  <= OP_PUSH;
         err_q <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (accept) begin
                  op_q  <= op_in;
                  cnt   <= '0;
                  err_q <= reject;
                  st    <= reject ? ST_FIN : ST_XFER;
               end
            end
            ST_XFER: begin
               if (last) st  <= ST_FIN;
               else      cnt <= cnt + CW'(1);
            end
            ST_FIN: begin
               st    <= ST_IDLE;
               err_q <= 1'b0;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/stk_sp.sv
module stk_sp #(
   parameter int                DATA_W    = 16,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_dn,
   input  logic              step_up,
   input  logic              load_en,
   input  logic [DATA_W-1:0] load_val,
   output logic [DATA_W-1:0] sp
);

   localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sp <= RESET_VAL;
      else if (load_en) sp <= load_val;
      else if (step_dn) sp <= sp - STEP;
      else if (step_up) sp <= sp + STEP;
   end

endmodule

// File: rtl/stk_sel.sv
module stk_sel #(
   parameter int DATA_W = 16,
   parameter int NREG   = 8,
   parameter int SP_IDX = 4
) (
   input  logic [NREG*DATA_W-1:0]    rf_flat,
   input  logic [$clog2(NREG)-1:0]   cnt,
   input  logic                      multi,
   input  logic [DATA_W-1:0]         src_q,
   input  logic [DATA_W-1:0]         sp_orig,
   input  logic [$clog2(NREG):0]     dst_q,
   output logic [DATA_W-1:0]         wdata,
   output logic [$clog2(NREG):0]     pop_code,
   output logic                      pop_wr,
   output logic                      pop_ldsp
);

   localparam int CW    = $clog2(NREG);
   localparam int DST_W = CW + 1;
   localparam logic [CW-1:0]    TOP_IDX = CW'(NREG - 1);
   localparam logic [CW-1:0]    SPI_C   = CW'(SP_IDX);
   localparam logic [DST_W-1:0] SPI_D   = DST_W'(SP_IDX);

   logic [DATA_W-1:0] slot [NREG];
   logic              sp_slot_unused;

   // push-all image: each register, with the pointer slot replaced
   for (genvar g = 0; g < NREG; g++) begin : g_slot
      if (g == SP_IDX) begin : g_ptr
         assign slot[g]        = sp_orig;
         assign sp_slot_unused = ^rf_flat[g*DATA_W +: DATA_W];
      end else begin : g_reg
         assign slot[g] = rf_flat[g*DATA_W +: DATA_W];
      end
   end

   logic [CW-1:0] ridx;
   assign ridx  = TOP_IDX - cnt;
   assign wdata = multi ? slot[cnt] : src_q;

   always_comb begin
      if (multi) begin
         pop_code = {1'b0, ridx};
         pop_wr   = (ridx != SPI_C);
         pop_ldsp = 1'b0;
      end else begin
         pop_code = dst_q;
         pop_wr   = (dst_q != SPI_D);
         pop_ldsp = (dst_q == SPI_D);
      end
   end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
   import stk_pkg::*;
#(
   parameter int                DATA_W   = 16,
   parameter int                NREG     = 8,
   parameter int                SP_IDX   = 4,
   parameter logic [DATA_W-1:0] SP_RESET = 16'h0180
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  start,
   input  logic [1:0]                            op,
   input  logic                                  byte_op,
   input  logic [DATA_W-1:0]                     src_word,
   input  logic [$clog2(NREG):0]                 dst,
   input  logic [NREG*DATA_W-1:0]                rf_flat,
   output logic [DATA_W-$clog2(DATA_W/8)-1:0]    mem_addr,
   output logic [DATA_W-1:0]                     mem_wdata,
   output logic                                  mem_we,
   output logic                                  mem_re,
   input  logic [DATA_W-1:0]                     mem_rdata,
   output logic                                  wb_en,
   output logic [$clog2(NREG):0]                 wb_dst,
   output logic [DATA_W-1:0]                     wb_data,
   output logic [DATA_W-1:0]                     sp_out,
   output logic                                  busy,
   output logic                                  done,
   output logic                                  err
);

   localparam int CW     = $clog2(NREG);
   localparam int DST_W  = CW + 1;
   localparam int LG     = $clog2(DATA_W / 8);
   localparam logic [DATA_W-1:0] STEP    = DATA_W'(DATA_W / 8);
   localparam logic [DST_W-1:0]  CS_CODE = DST_W'(NREG + 1);

   if ((DATA_W % 8) != 0 || DATA_W < 16) begin : g_bad_width
      $error("stk_seq: DATA_W must be a multiple of 8 and at least 16");
   end
   if (NREG < 2 || NREG != (1 << CW)) begin : g_bad_nreg
      $error("stk_seq: NREG must be a power of two, at least 2");
   end
   if (SP_IDX < 0 || SP_IDX >= NREG) begin : g_bad_spidx
      $error("stk_seq: SP_IDX must index a register");
   end

   stk_st_e           st;
   stk_op_e           op_q;
   logic [CW-1:0]     cnt;
   logic              err_q, accept, last, reject;
   logic [DATA_W-1:0] sp, sp_orig, src_q, acc_addr, wdata;
   logic [DST_W-1:0]  dst_q, pop_code, pend_dst;
   logic              pop_wr, pop_ldsp, pend_v, ldsp_q;
   logic              xfer, fin, rd;

   assign reject = byte_op ||
                   (op_is_read(stk_op_e'(op)) && !op_is_multi(stk_op_e'(op))
                    && dst == CS_CODE);

   stk_ctrl #(.NREG(NREG)) i_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .reject (reject),
      .op_in  (stk_op_e'(op)),
      .st     (st),
      .cnt    (cnt),
      .op_q   (op_q),
      .err_q  (err_q),
      .accept (accept),
      .last   (last)
   );

   assign xfer = (st == ST_XFER);
   assign fin  = (st == ST_FIN);
   assign rd   = op_is_read(op_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_orig <= '0;
         src_q   <= '0;
         dst_q   <= '0;
      end else if (accept) begin
         sp_orig <= sp;
         src_q   <= src_word;
         dst_q   <= dst;
      end
   end

   stk_sp #(.DATA_W(DATA_W), .RESET_VAL(SP_RESET)) i_sp (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_dn  (mem_we),
      .step_up  (mem_re),
      .load_en  (fin && ldsp_q),
      .load_val (mem_rdata),
      .sp       (sp)
   );

   stk_sel #(.DATA_W(DATA_W), .NREG(NREG), .SP_IDX(SP_IDX)) i_sel (
      .rf_flat  (rf_flat),
      .cnt      (cnt),
      .multi    (op_is_multi(op_q)),
      .src_q    (src_q),
      .sp_orig  (sp_orig),
      .dst_q    (dst_q),
      .wdata    (wdata),
      .pop_code (pop_code),
      .pop_wr   (pop_wr),
      .pop_ldsp (pop_ldsp)
   );

   // push addresses the slot below the pointer, pop the slot at it
   assign acc_addr  = rd ? sp : (sp - STEP);
   assign mem_addr  = acc_addr[DATA_W-1:LG];
   assign mem_wdata = wdata;
   assign mem_we    = xfer && !rd;
   assign mem_re    = xfer && rd;

   // read data returns one cycle late: hold the destination until then
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v   <= 1'b0;
         pend_dst <= '0;
         ldsp_q   <= 1'b0;
      end else begin
         pend_v <= mem_re && pop_wr;
         ldsp_q <= mem_re && pop_ldsp;
         if (mem_re) pend_dst <= pop_code;
      end
   end

   assign wb_en   = pend_v;
   assign wb_dst  = pend_dst;
   assign wb_data = mem_rdata;
   assign sp_out  = sp;
   assign busy    = (st != ST_IDLE);
   assign done    = fin;
   assign err     = fin && err_q;

endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
   parameter int DATA_W = 16,
   parameter int NREG   = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    mem_we,
   input logic                    mem_re,
   input logic                    wb_en,
   input logic [$clog2(NREG):0]   wb_dst,
   input logic [DATA_W-1:0]       sp_out,
   input logic                    busy,
   input logic                    done,
   input logic                    err
);

   localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);
   localparam logic [$clog2(NREG):0] CS_CODE = ($clog2(NREG)+1)'(NREG + 1);

   p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> sp_out == $past(sp_out) - STEP);

   p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> sp_out == $past(sp_out) + STEP);

   p_wb_follows_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> $past(mem_re));

   p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && !mem_we && !mem_re));

   p_cs_never_written_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_dst != CS_CODE));

   p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   p_single_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind stk_seq stk_seq_chk #(.DATA_W(DATA_W), .NREG(NREG)) i_stk_seq_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .mem_we (mem_we),
   .mem_re (mem_re),
   .wb_en  (wb_en),
   .wb_dst (wb_dst),
   .sp_out (sp_out),
   .busy   (busy),
   .done   (done),
   .err    (err)
);

// File: tb/test_stk_seq.sv
`timescale 1ns/1ps
module test_stk_seq;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [1:0]   op = 2'd0;
   logic         byte_op = 1'b0;
   logic [15:0]  src_word = '0;
   logic [3:0]   dst = '0;
   logic [127:0] rf_flat;
   logic [14:0]  mem_addr;
   logic [15:0]  mem_wdata, mem_rdata, wb_data, sp_out;
   logic         mem_we, mem_re, wb_en, busy, done, err;
   logic [3:0]   wb_dst;

   logic [15:0]  rf [8];
   logic [15:0]  mem [256];
   logic [15:0]  saved [2][8];
   logic [15:0]  sp_exp;
   int           n_chk = 0;
   int           n_err = 0;
   bit           finished = 0;

   always #10 clk = ~clk;

   always_comb
      for (int g = 0; g < 8; g++) rf_flat[g*16 +: 16] = rf[g];

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
   end

   stk_seq i_stk_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .byte_op(byte_op),
      .src_word(src_word), .dst(dst), .rf_flat(rf_flat), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
      .mem_rdata(mem_rdata), .wb_en(wb_en), .wb_dst(wb_dst), .wb_data(wb_data),
      .sp_out(sp_out), .busy(busy), .done(done), .err(err)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic kick(input logic [1:0] o, input logic b, input logic [15:0] s,
                       input logic [3:0] d);
      op = o; byte_op = b; src_word = s; dst = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0; byte_op = 1'b0;
   endtask

   task automatic push1(input logic [15:0] v);
      kick(2'd0, 1'b0, v, 4'd0);
      chk(mem_we && !mem_re, "R2 write strobe", {mem_we, mem_re}, 2'b10);
      chk(mem_addr == 15'((sp_exp - 16'd2) >> 1), "R2 address", mem_addr,
          (sp_exp - 16'd2) >> 1);
      chk(mem_wdata == v, "R2 data", mem_wdata, v);
      sp_exp = sp_exp - 16'd2;
      @(negedge clk);
      chk(done && !err && !mem_we, "R2 done", {done, err, mem_we}, 3'b100);
      chk(sp_out == sp_exp, "R2 pointer", sp_out, sp_exp);
      @(negedge clk);
   endtask

   task automatic pop1(input logic [3:0] d, input logic [15:0] v);
      kick(2'd1, 1'b0, 16'h0, d);
      chk(mem_re && !mem_we, "R3 read strobe", {mem_re, mem_we}, 2'b10);
      chk(mem_addr == 15'(sp_exp >> 1), "R3 address", mem_addr, sp_exp >> 1);
      sp_exp = sp_exp + 16'd2;
      @(negedge clk);
      chk(done && !err, "R3 done", {done, err}, 2'b10);
      chk(sp_out == sp_exp, "R3 pointer", sp_out, sp_exp);
      if (d == 4'd4) begin
         chk(!wb_en, "R9 no writeback", wb_en, 0);
         @(negedge clk);
         chk(sp_out == v, "R9 pointer load", sp_out, v);
         sp_exp = v;
      end else begin
         chk(wb_en && wb_dst == d, "R3 R12 writeback dest", {wb_en, wb_dst},
             {1'b1, d});
         chk(wb_data == v, "R3 writeback data", wb_data, v);
         @(negedge clk);
      end
   endtask

   task automatic pushall(input int lvl, input logic [15:0] seed);
      logic [15:0] sp0;
      sp0 = sp_exp;
      for (int g = 0; g < 8; g++) rf[g] = seed + 16'(g) * 16'h0F13;
      rf[4] = 16'hDEAD;
      for (int g = 0; g < 8; g++) saved[lvl][g] = (g == 4) ? sp0 : rf[g];
      kick(2'd2, 1'b0, 16'h0, 4'd0);
      for (int k = 0; k < 8; k++) begin
         chk(mem_we && !mem_re, "R4 write strobe", {mem_we, mem_re}, 2'b10);
         chk(mem_addr == 15'((sp0 - 16'(2 * (k + 1))) >> 1), "R4 address",
             mem_addr, (sp0 - 16'(2 * (k + 1))) >> 1);
         chk(mem_wdata == saved[lvl][k], "R4 data order", mem_wdata,
             saved[lvl][k]);
         if (k == 2) begin op = 2'd1; dst = 4'd0; start = 1'b1; end  // R10
         if (k == 3) start = 1'b0;
         @(negedge clk);
      end
      chk(done && !err, "R5 done after last write", {done, err}, 2'b10);
      chk(sp_out == sp0 - 16'd16, "R5 pointer", sp_out, sp0 - 16'd16);
      sp_exp = sp0 - 16'd16;
      @(negedge clk);
      chk(!busy && !mem_re && !mem_we, "R10 start while busy ignored",
          {busy, mem_re, mem_we}, 0);
   endtask

   task automatic popall(input int lvl);
      logic [15:0] sp0;
      int idx;
      sp0 = sp_exp;
      kick(2'd3, 1'b0, 16'h0, 4'd0);
      for (int j = 0; j <= 8; j++) begin
         if (j < 8) begin
            chk(mem_re && !mem_we, "R6 read strobe", {mem_re, mem_we}, 2'b10);
            chk(mem_addr == 15'((sp0 + 16'(2 * j)) >> 1), "R6 address",
                mem_addr, (sp0 + 16'(2 * j)) >> 1);
         end
         if (j >= 1) begin
            idx = 8 - j;
            if (idx == 4) chk(!wb_en, "R6 pointer word dropped", wb_en, 0);
            else begin
               chk(wb_en && wb_dst == 4'(idx), "R6 writeback index",
                   {wb_en, wb_dst}, {1'b1, 4'(idx)});
               chk(wb_data == saved[lvl][idx], "R6 writeback data", wb_data,
                   saved[lvl][idx]);
            end
         end else chk(!wb_en, "R6 no early writeback", wb_en, 0);
         if (j == 8) begin
            chk(done && !err, "R6 done with last writeback", {done, err}, 2'b10);
            chk(sp_out == sp0 + 16'd16, "R6 pointer", sp_out, sp0 + 16'd16);
         end
         @(negedge clk);
      end
      sp_exp = sp0 + 16'd16;
   endtask

   task automatic reject_case(input logic [1:0] o, input logic b,
                              input logic [3:0] d, input string req);
      kick(o, b, 16'h5A5A, d);
      chk(done && err, {req, " done+err"}, {done, err}, 2'b11);
      chk(!mem_we && !mem_re, {req, " no access"}, {mem_we, mem_re}, 0);
      @(negedge clk);
      chk(!busy && !wb_en && sp_out == sp_exp, {req, " pointer kept"}, sp_out,
          sp_exp);
   endtask

   task automatic report;
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      report();
   end

   initial begin
      logic [15:0] v;
      for (int g = 0; g < 8; g++) rf[g] = '0;
      sp_exp = 16'h0180;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !err, "R1 idle", {busy, done, err}, 0);
      chk(!mem_we && !mem_re && !wb_en, "R1 strobes", {mem_we, mem_re, wb_en}, 0);
      chk(sp_out == 16'h0180, "R1 pointer", sp_out, 16'h0180);

      // R2 R3 R12 sweep of every legal single-pop destination
      for (int d = 0; d < 12; d++) begin
         if (d != 4 && d != 9) begin
            v = 16'h1000 + 16'(d) * 16'h0B07;
            push1(v);
            pop1(4'(d), v);
         end
      end
      // LIFO order over three words
      push1(16'hA001); push1(16'hB002); push1(16'hC003);
      pop1(4'd0, 16'hC003); pop1(4'd1, 16'hB002); pop1(4'd2, 16'hA001);
      // R9 pop into the stack pointer
      push1(16'h0170);
      pop1(4'd4, 16'h0170);
      // R4 R5 R6 R10 nested push-all / pop-all
      pushall(0, 16'h1234);
      pushall(1, 16'h8765);
      popall(1);
      popall(0);
      // R7 R8 rejections
      reject_case(2'd0, 1'b1, 4'd0, "R7 byte push");
      reject_case(2'd1, 1'b1, 4'd2, "R7 byte pop");
      reject_case(2'd1, 1'b0, 4'd9, "R8 code segment pop");
      // still functional after rejections
      push1(16'h7E7E);
      pop1(4'd6, 16'h7E7E);
      report();
   end

endmodule